// File: doc/BRIEF.md
# Four-Phase Handshake Monitor

This block is a passive, synchronous checker for one request/acknowledge pair on a memory port. A sender drives the request, a write-enable, an address and write data. A receiver answers with the acknowledge. On every rising clock edge the monitor samples these signals. It compares each sample with the one before it and records any break of the four-phase ordering rules. It also records any movement of the transfer fields while a request is waiting for its acknowledge.

Each rule has its own sticky flag. Rules that the sender must keep are reported apart from those the receiver must keep. A flag stays set until a one-cycle synchronous clear. The `err` output goes high whenever any flag is set.

Progress is checked by four dwell counters, one for each handshake phase. Each counter has its own programmable cycle limit, and a limit of zero turns that check off. A 16-bit counter records the number of handshakes that have run to completion. All inputs are taken to be synchronous to the monitor clock.

Top module: `hs4_monitor`

## Requirements
- R1: After reset, all of `viol`, `err` and `txn_cnt` read zero.
- R2: Every flag below appears in `viol` one cycle after the offending sample. `viol[0]` is set when req is sampled low after a sample with req high and ack low, meaning the sender withdrew a request that had not been acknowledged.
- R3: `viol[1]` is set when ack is sampled low after a sample with both req and ack high, meaning the receiver withdrew an acknowledge before the request ended.
- R4: `viol[2]` is set when req is sampled high after a sample with req low and ack high, meaning a new request was raised before the previous acknowledge ended.
- R5: `viol[3]` is set when ack is sampled high after a sample with both req and ack low, meaning an acknowledge arrived with no request.
- R6: `viol[4]` is set when req is sampled high, the previous sample had req high and ack low, and the value of {wen, addr, wdata} differs from that previous sample. The fields may change on the sample where req first rises. They may also change once ack has been seen high.
- R7: Each phase has its own timeout limit:
  - phase (req=1, ack=0) uses `lim_ack_rise` and reports on `viol[5]`;
  - phase (1,1) uses `lim_req_fall` and reports on `viol[6]`;
  - phase (0,1) uses `lim_ack_fall` and reports on `viol[7]`;
  - phase (0,0) uses `lim_req_rise` and reports on `viol[8]`.
  A phase may last for `limit` consecutive samples. Its flag is set when the phase is seen for the `limit+1`-th sample in a row.
- R8: A limit value of zero disables its timeout check, however long the phase lasts.
- R9: `viol[9]` is set if req or ack is high at the first sample after reset. The ordering rules start from the second sample after reset.
- R10: Every flag stays set until `clr` is sampled high, and `clr` clears all flags. A violation found on the same sample as `clr` still sets its flag.
- R11: `err` is high exactly when at least one bit of `viol` is set.
- R12: `txn_cnt` counts up by one, wrapping at 16 bits, each time ack is sampled low after a sample with req low and ack high. Each such event marks one completed handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Clears all violation flags |
| req | input | 1 | Request from the sender |
| ack | input | 1 | Acknowledge from the receiver |
| wen | input | 1 | Write enable that travels with the request |
| addr | input | AW | Address that travels with the request |
| wdata | input | DW | Write data that travels with the request |
| lim_ack_rise | input | CW | Timeout limit for ack to rise, 0 = off |
| lim_req_fall | input | CW | Timeout limit for req to fall, 0 = off |
| lim_ack_fall | input | CW | Timeout limit for ack to fall, 0 = off |
| lim_req_rise | input | CW | Timeout limit for the next req, 0 = off |
| viol | output | 10 | Sticky per-rule violation flags |
| err | output | 1 | OR of all violation flags |
| txn_cnt | output | 16 | Count of completed handshakes |

## Verification
The embedded properties assume that req, ack and the transfer fields are clean synchronous levels, settled before each rising edge. They also assume that reset is held for at least one edge before the first sample that counts. The bench changes every input on the falling clock edge and holds reset across several edges. It then releases reset with req and ack low, except in the single test of the initial-state rule. The timeout tests load their limits before releasing reset, so the idle-phase counter never starts out beyond its limit.

// File: rtl/hs4_monitor.sv
module hs4_monitor #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          req,
  input  logic          ack,
  input  logic          wen,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [CW-1:0] lim_ack_rise,
  input  logic [CW-1:0] lim_req_fall,
  input  logic [CW-1:0] lim_ack_fall,
  input  logic [CW-1:0] lim_req_rise,
  output logic [9:0]    viol,
  output logic          err,
  output logic [15:0]   txn_cnt
);
  localparam int NV = 10;
  localparam int BW = AW + DW + 1;

  logic          started, prev_req, prev_ack;
  logic [BW-1:0] prev_bus;
  logic [BW-1:0] bus;
  logic [1:0]    ph;
  logic [CW-1:0] lim [4];
  logic [CW-1:0] cnt [4];
  logic [3:0]    tmo;
  logic [NV-1:0] det;
  logic          done_evt;

  assign bus = {wen, addr, wdata};
  // phase index: (1,0)->0, (1,1)->1, (0,1)->2, (0,0)->3
  assign ph  = {~req, req ^ ~ack};
  assign lim[0] = lim_ack_rise;
  assign lim[1] = lim_req_fall;
  assign lim[2] = lim_ack_fall;
  assign lim[3] = lim_req_rise;

  for (genvar i = 0; i < 4; i++) begin : g_live
    always_ff @(posedge clk) begin
      if (!rst_n)             cnt[i] <= '0;
      else if (ph == 2'(i))   cnt[i] <= (cnt[i] == '1) ? cnt[i] : cnt[i] + 1'b1;
      else                    cnt[i] <= '0;
    end
    assign tmo[i] = started && (ph == 2'(i)) && (lim[i] != '0) && (cnt[i] == lim[i]);
  end

  assign det[0]   = started & prev_req & ~prev_ack & ~req;
  assign det[1]   = started & prev_req & prev_ack & ~ack;
  assign det[2]   = started & ~prev_req & prev_ack & req;
  assign det[3]   = started & ~prev_req & ~prev_ack & ack;
  assign det[4]   = started & prev_req & ~prev_ack & req & (bus != prev_bus);
  assign det[8:5] = tmo;
  assign det[9]   = ~started & (req | ack);

  assign done_evt = started & ~prev_req & prev_ack & ~ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started  <= 1'b0;
      prev_req <= 1'b0;
      prev_ack <= 1'b0;
      prev_bus <= '0;
      viol     <= '0;
      txn_cnt  <= '0;
    end else begin
      started  <= 1'b1;
      prev_req <= req;
      prev_ack <= ack;
      prev_bus <= bus;
      viol     <= (clr ? '0 : viol) | det;
      if (done_evt) txn_cnt <= txn_cnt + 16'd1;
    end
  end

  assign err = |viol;

  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((viol & $past(viol)) == $past(viol)));

  // R12
  txn_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((txn_cnt - $past(txn_cnt)) <= 16'd1));

  // R2
  early_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $past(req) && !$past(ack) && !req) |=> viol[0]);

  // R5
  unsolicited_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !$past(req) && !$past(ack) && ack) |=> viol[3]);

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $past(req) && !$past(ack) && req && (addr != $past(addr))) |=> viol[4]);
endmodule

// File: tb/hs4_monitor_tb.sv
module hs4_monitor_tb;
  localparam int AW = 16, DW = 32, CW = 12;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, req = 1'b0, ack = 1'b0, wen = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [CW-1:0] l_ar = '0, l_rf = '0, l_af = '0, l_rr = '0;
  logic [9:0]  viol;
  logic        err;
  logic [15:0] txn_cnt;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  hs4_monitor #(.AW(AW), .DW(DW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .req(req), .ack(ack), .wen(wen),
    .addr(addr), .wdata(wdata), .lim_ack_rise(l_ar), .lim_req_fall(l_rf),
    .lim_ack_fall(l_af), .lim_req_rise(l_rr), .viol(viol), .err(err), .txn_cnt(txn_cnt));

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(logic r0 = 1'b0, logic a0 = 1'b0);
    rst_n = 1'b0; clr = 1'b0; req = r0; ack = a0;
    step(3);
    rst_n = 1'b1;
  endtask

  task automatic do_clear();
    clr = 1'b1; step(); clr = 1'b0;
  endtask

  task automatic good_hs();
    req = 1'b1; step(); ack = 1'b1; step(); req = 1'b0; step(); ack = 1'b0; step();
  endtask

  task automatic t_reset();
    do_reset(); step();
    check("R1 viol", 32'(viol), 0);
    check("R1 err", 32'(err), 0);
    check("R1 txn", 32'(txn_cnt), 0);
  endtask

  task automatic t_good();
    do_reset(); step();
    good_hs(); good_hs();
    wen = 1'b1; addr = 16'h1234; wdata = 32'hCAFE0001;
    good_hs();
    check("R12 txn after three", 32'(txn_cnt), 3);
    check("R11 err clean", 32'(err), 0);
    check("R2 clean", 32'(viol), 0);
  endtask

  task automatic t_r2();
    do_reset(); step();
    req = 1'b1; step(); req = 1'b0; step();
    check("R2 flag", 32'(viol), 32'h001);
    check("R11 err set", 32'(err), 1);
  endtask

  task automatic t_r3();
    do_reset(); step();
    req = 1'b1; step(); ack = 1'b1; step(); ack = 1'b0; step();
    check("R3 flag", 32'(viol), 32'h002);
  endtask

  task automatic t_r4();
    do_reset(); step();
    req = 1'b1; step(); ack = 1'b1; step(); req = 1'b0; step(); req = 1'b1; step();
    check("R4 flag", 32'(viol & 10'h004), 32'h004);
    check("R12 no count", 32'(txn_cnt), 0);
  endtask

  task automatic t_r5();
    do_reset(); step(2);
    ack = 1'b1; step();
    check("R5 flag", 32'(viol), 32'h008);
  endtask

  task automatic t_r6();
    do_reset(); step();
    addr = 16'h0010; req = 1'b1; step();
    addr = 16'h0011; step();
    check("R6 addr move", 32'(viol), 32'h010);
    do_clear();
    check("R10 cleared", 32'(viol), 0);
    ack = 1'b1; step(); wdata = 32'h55; wen = 1'b1; step();
    req = 1'b0; step(); ack = 1'b0; step();
    check("R6 move after ack ok", 32'(viol), 0);
    wdata = 32'h77; req = 1'b1; step(); step(2);
    check("R6 move at rise ok", 32'(viol), 0);
    wen = 1'b0; step();
    check("R6 wen move", 32'(viol), 32'h010);
    ack = 1'b1; step(); req = 1'b0; step(); ack = 1'b0; step();
  endtask

  task automatic t_r7();
    l_ar = 12'd3;
    do_reset(); step();
    req = 1'b1; step(3);
    check("R7 ack_rise at limit", 32'(viol), 0);
    step();
    check("R7 ack_rise over", 32'(viol), 32'h020);
    l_ar = '0;
    l_af = 12'd2;
    do_reset(); step();
    req = 1'b1; step(); ack = 1'b1; step(); req = 1'b0; step(2);
    check("R7 ack_fall at limit", 32'(viol), 0);
    step();
    check("R7 ack_fall over", 32'(viol), 32'h080);
    ack = 1'b0; l_af = '0;
    l_rr = 12'd4;
    do_reset(); step(4);
    check("R7 req_rise at limit", 32'(viol), 0);
    step();
    check("R7 req_rise over", 32'(viol), 32'h100);
    l_rr = '0;
    l_rf = 12'd1;
    do_reset(); step();
    req = 1'b1; step(); ack = 1'b1; step(2);
    check("R7 req_fall over", 32'(viol), 32'h040);
    req = 1'b0; step(); ack = 1'b0; step(); l_rf = '0;
  endtask

  task automatic t_r8();
    do_reset(); step();
    req = 1'b1; step(60);
    check("R8 zero limit", 32'(viol), 0);
    ack = 1'b1; step(); req = 1'b0; step(); ack = 1'b0; step();
  endtask

  task automatic t_r9();
    do_reset(1'b1, 1'b0); step();
    check("R9 init flag", 32'(viol[9]), 1);
    do_reset(); step(3);
    check("R9 clean start", 32'(viol), 0);
  endtask

  task automatic t_r10();
    do_reset(); step(2);
    ack = 1'b1; step(); ack = 1'b0; step(5);
    check("R10 sticky", 32'(viol), 32'h008);
    ack = 1'b1; clr = 1'b1; step(); clr = 1'b0;
    check("R10 set wins over clear", 32'(viol), 32'h008);
    ack = 1'b0; step(); do_clear();
    check("R10 clear", 32'(viol), 0);
    check("R11 err low", 32'(err), 0);
  endtask

  initial begin
    t_reset(); t_good(); t_r2(); t_r3(); t_r4(); t_r5(); t_r6();
    t_r7(); t_r8(); t_r9(); t_r10();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule